// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block derives the complete scan timing for a 1/160-duty passive matrix panel from a single oscillator clock. When it is the timing master, it produces a column strobe, an active-low frame marker and a pair of row-driver level-select bits. It also exposes its line and half-frame position to the rest of the chip. When it is a follower, its own generation stops and its outputs go quiet. It then counts the strobe and frame signals arriving from another chip, so it keeps the same line and half-frame position and its own private copy of the level-select bits for later comparison.

Each strobe period spans 16 oscillator clocks. A half-frame holds 81 lines and a frame holds two half-frames, so one frame is 2592 clocks. After reset the display-off output is held asserted for four whole frames and only then follows the external display-off input. The oscillator itself and the gray-level modulation are outside this block.

Top module: `lcd_scan_timer`

## Requirements
- R1: In master mode, `stbOut` repeats every 16 clocks: high for 8 clocks, then low for 8. Every rising edge of `stbOut` starts a new line.
- R2: `lineIdx` counts 0 to 80 and then wraps to 0. `halfIdx` toggles on each wrap. One frame is therefore 162 lines, which is 2592 clocks.
- R3: In master mode, `frmNOut` goes low once per half-frame and stays low for exactly 16 clocks. It is low from clock 4 of line 0 through clock 3 of line 1, where clock 0 is the cycle in which the strobe rises. It never changes in the same cycle as `stbOut`.
- R4: The first cycle after a synchronous reset is released is clock 0 of line 0 of half 0. While reset is held, the outputs read `stbOut`=0, `frmNOut`=1, `lvl1Out`=`lvl2Out`=0, `lineIdx`=80, `halfIdx`=1 and `dispOffNOut`=0.
- R5: A 4-bit strobe counter p starts at 0 on the first line after reset and advances by one on every line. It does not restart at frame boundaries. The level-select bits are L1 = (p < 8) and L2 = (not p[0]) xor p[2] xor p[3]. Over groups of four lines this gives L1 = 1111,1111,0000,0000 and L2 = 1010,0101,0101,1010.
- R6: In slave mode (`masterMode`=0), `stbOut`=0, `frmNOut`=1 and `lvl1Out`=`lvl2Out`=0. In master mode, `lvl1Out` and `lvl2Out` equal the local level-select bits.
- R7: In slave mode, a rising edge on `stbIn` advances the line counter, the half-frame bit and p, in the clock edge at which `stbIn` is first seen high.
- R8: In slave mode, a falling edge on `frmNIn` forces `lineIdx` to 0. If it coincides with a strobe rise, the line is still forced to 0, while p and `halfIdx` advance as for the strobe alone.
- R9: `lvl1Local` and `lvl2Local` carry the R5 bits in both modes.
- R10: `dispOffNOut` stays 0 until the fifth frame begins after reset, that is 1 + 4×2592 clocks after release in master mode. From then on it equals `dispOffNIn`.
- R11: `dispOffNIn`=0 forces `dispOffNOut`=0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rstN | input | 1 | synchronous reset, active low |
| masterMode | input | 1 | 1 = generate timing, 0 = follow external timing |
| stbIn | input | 1 | external strobe in slave mode |
| frmNIn | input | 1 | external frame marker in slave mode, active low |
| dispOffNIn | input | 1 | display-off request, active low |
| stbOut | output | 1 | generated column strobe |
| frmNOut | output | 1 | generated frame marker, active low |
| lvl1Out | output | 1 | row level-select bit 1 (master only) |
| lvl2Out | output | 1 | row level-select bit 2 (master only) |
| lvl1Local | output | 1 | local level-select bit 1, both modes |
| lvl2Local | output | 1 | local level-select bit 2, both modes |
| lineIdx | output | 7 | current line within the half-frame |
| halfIdx | output | 1 | current half-frame |
| dispOffNOut | output | 1 | display-off output, active low |

## Verification
In slave mode, a strobe rise and a frame fall can arrive in the same cycle. The counters then have to apply both the line advance and the resynchronisation together. The bench provokes this in the normal way, with the frame edge at the wrap, and also by dropping the frame input on the same cycle as a strobe rise partway through a half-frame. It then expects line 0, with the half-frame bit and level counter advanced exactly as for a lone strobe. In master mode, the end of the display-off hold and a random display-off request overlap. The bench judges that overlap against a cycle count from reset.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // Strobes from the control side to the counter datapath
  typedef struct packed {
    logic step;     // a new line begins at this edge
    logic resync;   // external frame fall seen (slave)
    logic stbHigh;  // generated strobe level
    logic frmLead;  // master phase at or past the quarter point
    logic frmTail;  // master phase before the quarter point
  } scanCtl_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int CLK_PER_LINE = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     masterMode,
  input  logic     stbIn,
  input  logic     frmNIn,
  output scanCtl_t ctl
);
  localparam int PH_W = $clog2(CLK_PER_LINE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_LINE - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLK_PER_LINE / 2);
  localparam logic [PH_W-1:0] PH_QTR  = PH_W'(CLK_PER_LINE / 4);

  logic [PH_W-1:0] phase;
  logic stbPrev, frmPrev;

  // Phase parks on its last value in reset and in slave mode, so the
  // first master edge after release is a line step.
  always_ff @(posedge clk) begin
    if (!rstN || !masterMode) phase <= PH_LAST;
    else if (phase == PH_LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbPrev <= 1'b0;
      frmPrev <= 1'b1;
    end else begin
      stbPrev <= stbIn;
      frmPrev <= frmNIn;
    end
  end

  always_comb begin
    ctl.step    = masterMode ? (phase == PH_LAST) : (stbIn && !stbPrev);
    ctl.resync  = !masterMode && !frmNIn && frmPrev;
    ctl.stbHigh = masterMode && (phase < PH_HALF);
    ctl.frmLead = masterMode && (phase >= PH_QTR);
    ctl.frmTail = masterMode && (phase < PH_QTR);
  end
endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
#(
  parameter int LINES_PER_HALF = 81,
  parameter int HOLD_FRAMES    = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     masterMode,
  input  logic     dispOffNIn,
  input  scanCtl_t ctl,
  output logic     stbOut,
  output logic     frmNOut,
  output logic     lvl1Out,
  output logic     lvl2Out,
  output logic     lvl1Local,
  output logic     lvl2Local,
  output logic [$clog2(LINES_PER_HALF)-1:0] lineIdx,
  output logic     halfIdx,
  output logic     dispOffNOut
);
  localparam int LN_W = $clog2(LINES_PER_HALF);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(LINES_PER_HALF - 1);
  localparam logic [LN_W-1:0] LN_ONE  = LN_W'(1);
  localparam int HC_W = $clog2(HOLD_FRAMES + 2);
  localparam logic [HC_W-1:0] HC_DONE = HC_W'(HOLD_FRAMES + 1);

  logic [LN_W-1:0] lineCnt;
  logic            halfSel;
  logic [3:0]      seqCnt;
  logic [HC_W-1:0] holdCnt;
  logic            lineWrap, frameStart;

  assign lineWrap   = (lineCnt == LN_LAST);
  assign frameStart = ctl.step && lineWrap && halfSel;

  // Reset parks every counter on the last line of the second half so
  // the first step lands on line 0, half 0, level position 0.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= LN_LAST;
      halfSel <= 1'b1;
      seqCnt  <= 4'hF;
      holdCnt <= '0;
    end else begin
      if (ctl.step) begin
        seqCnt <= seqCnt + 4'd1;
        if (lineWrap) halfSel <= ~halfSel;
      end
      if (ctl.resync) lineCnt <= '0;
      else if (ctl.step) lineCnt <= lineWrap ? '0 : lineCnt + 1'b1;
      if (frameStart && holdCnt != HC_DONE) holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    lvl1Local   = !seqCnt[3];
    lvl2Local   = !seqCnt[0] ^ seqCnt[2] ^ seqCnt[3];
    lvl1Out     = masterMode && lvl1Local;
    lvl2Out     = masterMode && lvl2Local;
    stbOut      = ctl.stbHigh;
    frmNOut     = !((lineCnt == '0 && ctl.frmLead) || (lineCnt == LN_ONE && ctl.frmTail));
    lineIdx     = lineCnt;
    halfIdx     = halfSel;
    dispOffNOut = (holdCnt == HC_DONE) && dispOffNIn;
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int CLK_PER_LINE   = 16,
  parameter int LINES_PER_HALF = 81,
  parameter int HOLD_FRAMES    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterMode,
  input  logic stbIn,
  input  logic frmNIn,
  input  logic dispOffNIn,
  output logic stbOut,
  output logic frmNOut,
  output logic lvl1Out,
  output logic lvl2Out,
  output logic lvl1Local,
  output logic lvl2Local,
  output logic [$clog2(LINES_PER_HALF)-1:0] lineIdx,
  output logic halfIdx,
  output logic dispOffNOut
);
  scanCtl_t ctl;

  lcd_scan_ctrl #(.CLK_PER_LINE(CLK_PER_LINE)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .stbIn(stbIn), .frmNIn(frmNIn), .ctl(ctl)
  );

  lcd_scan_dp #(.LINES_PER_HALF(LINES_PER_HALF), .HOLD_FRAMES(HOLD_FRAMES)) u_dp (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .dispOffNIn(dispOffNIn),
    .ctl(ctl), .stbOut(stbOut), .frmNOut(frmNOut), .lvl1Out(lvl1Out),
    .lvl2Out(lvl2Out), .lvl1Local(lvl1Local), .lvl2Local(lvl2Local),
    .lineIdx(lineIdx), .halfIdx(halfIdx), .dispOffNOut(dispOffNOut)
  );
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int LINES_PER_HALF = 81
) (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic dispOffNIn,
  input logic stbOut,
  input logic frmNOut,
  input logic lvl1Out,
  input logic lvl2Out,
  input logic lvl2Local,
  input logic [$clog2(LINES_PER_HALF)-1:0] lineIdx,
  input logic dispOffNOut
);
  localparam int LN_W = $clog2(LINES_PER_HALF);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(LINES_PER_HALF - 1);

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!stbOut && frmNOut && !lvl1Out && !lvl2Out)); // R6

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    lineIdx <= LN_LAST); // R2

  AST_DOFF_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    !dispOffNIn |-> !dispOffNOut); // R11

  AST_LINE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(masterMode) && $rose(stbOut)) |-> (lineIdx != $past(lineIdx))); // R1

  AST_FRM_OFF_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !$stable(frmNOut)) |-> $stable(stbOut)); // R3

  AST_LVL_WITH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(masterMode) && !$stable(lvl2Local)) |-> $rose(stbOut)); // R5
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.LINES_PER_HALF(LINES_PER_HALF)) u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .dispOffNIn(dispOffNIn),
  .stbOut(stbOut), .frmNOut(frmNOut), .lvl1Out(lvl1Out), .lvl2Out(lvl2Out),
  .lvl2Local(lvl2Local), .lineIdx(lineIdx), .dispOffNOut(dispOffNOut)
);

// File: tb/test_lcd_scan_timer.sv
`timescale 1ns/1ps
module test_lcd_scan_timer;
  localparam int CPL = 16;
  localparam int LPH = 81;
  localparam int HOLD = 4;
  localparam int FRAME_CLK = 2 * LPH * CPL;
  localparam int HOLD_END = 1 + HOLD * FRAME_CLK;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic stbIn = 1'b0;
  logic frmNIn = 1'b1;
  logic dispOffNIn = 1'b1;
  logic stbOut, frmNOut, lvl1Out, lvl2Out, lvl1Local, lvl2Local, halfIdx, dispOffNOut;
  logic [6:0] lineIdx;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // slave-side expected state
  int eLine, eHalf, eSeq, eHold;

  always #2 clk = ~clk;

  lcd_scan_timer i_lcd_scan_timer (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .stbIn(stbIn),
    .frmNIn(frmNIn), .dispOffNIn(dispOffNIn), .stbOut(stbOut),
    .frmNOut(frmNOut), .lvl1Out(lvl1Out), .lvl2Out(lvl2Out),
    .lvl1Local(lvl1Local), .lvl2Local(lvl2Local), .lineIdx(lineIdx),
    .halfIdx(halfIdx), .dispOffNOut(dispOffNOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit lvl1Of(input int p);
    return (p % 16) < 8;
  endfunction

  function automatic bit lvl2Of(input int p);
    int q = p % 16;
    return (((q & 1) == 0) ^ (((q >> 2) & 1) == 1) ^ (((q >> 3) & 1) == 1));
  endfunction

  task automatic doReset(input bit mst);
    @(negedge clk);
    rstN = 1'b0;
    masterMode = mst;
    stbIn = 1'b0;
    frmNIn = 1'b1;
    repeat (3) @(negedge clk);
    // R4: reset-state outputs
    chk(stbOut == 1'b0, "R4 stb", stbOut, 0);
    chk(frmNOut == 1'b1, "R4 frm", frmNOut, 1);
    chk(lvl1Out == 1'b0 && lvl2Out == 1'b0, "R4 lvl", {lvl1Out, lvl2Out}, 0);
    chk(lineIdx == 7'd80 && halfIdx == 1'b1, "R4 pos", {halfIdx, lineIdx}, {1'b1, 7'd80});
    chk(dispOffNOut == 1'b0, "R4 doff", dispOffNOut, 0);
    rstN = 1'b1;
  endtask

  // Master run: t counts edges since release; expected values computed from R1..R5, R10, R11
  task automatic runMaster(input int cycles);
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        int k = t - 1;
        int ph = k % CPL;
        int sIdx = k / CPL;
        int ln = sIdx % LPH;
        int hf = (sIdx / LPH) % 2;
        bit eStb = ph < CPL / 2;
        bit eFrm = !((ln == 0 && ph >= CPL / 4) || (ln == 1 && ph < CPL / 4));
        bit eDoff = (t >= HOLD_END) && dispOffNIn;
        chk(stbOut == eStb, "R1 stb", stbOut, eStb);
        chk(lineIdx == ln && halfIdx == hf, "R2 pos", {halfIdx, lineIdx}, hf * 128 + ln);
        chk(frmNOut == eFrm, "R3 frm", frmNOut, eFrm);
        chk(lvl1Out == lvl1Of(sIdx) && lvl2Out == lvl2Of(sIdx), "R5 lvl",
            {lvl1Out, lvl2Out}, {lvl1Of(sIdx), lvl2Of(sIdx)});
        chk(lvl1Local == lvl1Out && lvl2Local == lvl2Out, "R9 local", {lvl1Local, lvl2Local},
            {lvl1Out, lvl2Out});
        chk(dispOffNOut == eDoff, dispOffNIn ? "R10 hold" : "R11 force", dispOffNOut, eDoff);
      end
      dispOffNIn = ($urandom_range(0, 7) != 0);
    end
  endtask

  task automatic slvCheck(input string tag);
    chk(lineIdx == eLine && halfIdx == eHalf, {tag, " R7 pos"}, {halfIdx, lineIdx}, eHalf * 128 + eLine);
    chk(lvl1Local == lvl1Of(eSeq) && lvl2Local == lvl2Of(eSeq), {tag, " R9 lvl"},
        {lvl1Local, lvl2Local}, {lvl1Of(eSeq), lvl2Of(eSeq)});
    chk(!stbOut && frmNOut && !lvl1Out && !lvl2Out, {tag, " R6 quiet"},
        {stbOut, frmNOut, lvl1Out, lvl2Out}, 4'b0100);
    chk(dispOffNOut == ((eHold > HOLD) && dispOffNIn), {tag, " R10 slave"}, dispOffNOut,
        (eHold > HOLD) && dispOffNIn);
  endtask

  // one strobe rise, optionally with a frame fall in the same cycle (R8)
  task automatic slvRise(input bit withFrm);
    @(negedge clk);
    stbIn = 1'b1;
    if (withFrm) frmNIn = 1'b0;
    if (eLine == LPH - 1 && eHalf == 1 && eHold <= HOLD) eHold++;
    eSeq = (eSeq + 1) % 16;
    if (eLine == LPH - 1) begin eLine = 0; eHalf ^= 1; end
    else eLine++;
    if (withFrm) eLine = 0;
    @(negedge clk);
    slvCheck(withFrm ? "R8 coincide" : "step");
    stbIn = 1'b0;
    frmNIn = 1'b1;
    repeat ($urandom_range(1, 4)) @(negedge clk);
    chk(lineIdx == eLine, "R7 hold low", lineIdx, eLine);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    doReset(1'b1);
    runMaster(HOLD_END + 3 * CPL * LPH);

    doReset(1'b0);
    eLine = LPH - 1; eHalf = 1; eSeq = 15; eHold = 0;
    for (int i = 0; i < 200; i++) begin
      bit wrapNext = (eLine == LPH - 1);
      if (i == 40) slvRise(1'b1);          // frame fall mid half-frame with a strobe
      else slvRise(wrapNext);              // regular frame edge on the wrap
      if (i == 100) begin                  // lone frame fall, no strobe
        @(negedge clk);
        frmNIn = 1'b0;
        eLine = 0;
        @(negedge clk);
        slvCheck("R8 alone");
        frmNIn = 1'b1;
      end
    end

    // mid-run reset back to master: counters restart from line 0
    doReset(1'b1);
    runMaster(2 * CPL * LPH + 50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule